// File: doc/BRIEF.md
# Register-Mapped GPIO Bank with Line Interrupts

This block is a bank of eight general-purpose I/O lines behind a simple APB-style register bus. Each line has a direction bit that decides whether the block drives the pad or only observes it. Output values are written through a data window. In that window, address bits 9 down to 2 act as a per-line mask: one bus write can update any subset of lines and leave the others as they are. Reads of the window return only the selected lines.

Every line can raise an interrupt. It can trigger on a level with a chosen polarity, on one edge with a chosen direction, or on both edges. Edge events are held in a status bit until software writes a one to the clear register. Level status is never held: it follows the synchronized pin. An enable register filters the raw status into a masked status, and a single interrupt output is the OR of the masked bits. Pad inputs pass through a two-flop synchronizer before anything inside the block uses them.

Bus accesses follow the usual two-phase setup/access order. Every access completes in its access phase with no wait states, so the bus never applies back-pressure and the block has no ready output. Writes take effect on the clock edge that ends the access phase. Read data is valid during the access phase.

Top module: `gpio_bank`

## Requirements
- R1: After reset all lines are inputs (pad_oe = 0), pad_out = 0, irq = 0, and the direction (0x400) and enable (0x410) registers read 0.
- R2: A direction bit of 1 at offset 0x400 drives pad_oe for that line, and the bit reads back as written. pad_out carries the line's output value.
- R3: A write below 0x400 updates only the lines whose bit in paddr[9:2] is 1 and whose direction bit is 1. Line n alone is reached at byte offset 1<<(n+2). pad_out does not change in any cycle without such a write.
- R4: A read below 0x400 returns, for each line masked in by paddr[9:2], its output value if it is an output or its synchronized pin if it is an input. Lines that are masked out read as 0.
- R5: A pad change reaches the interrupt logic after two clock edges. A level interrupt asserts after the second rising edge that follows the pad change, and not after the first.
- R6: With sense bit 0 (offset 0x404) and both-edges bit 0 (offset 0x408), polarity bit 1 (offset 0x40C) latches status on a rising edge and 0 latches status on a falling edge. The opposite edge sets nothing, and the latched bit stays set after the pin returns.
- R7: With sense 0 and both-edges 1, rising and falling edges both latch status whatever the polarity bit holds.
- R8: With sense bit 1, raw status is 1 while the synchronized pin equals the polarity bit (1 = active high, 0 = active low). It drops when the pin leaves that level, and a clear write does not remove it.
- R9: Masked status (offset 0x418) equals raw status (offset 0x414) ANDed with the enable register (offset 0x410), and irq is 1 exactly when some masked bit is 1.
- R10: Writing 1 to a bit at offset 0x41C clears that line's latched edge status. Bits written 0 are unaffected, and the register reads 0.
- R11: If an edge event and a clear write hit the same line in the same cycle, the status remains set.
- R12: Writes to the raw and masked status offsets change neither register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | Bus select, high in setup and access phases |
| penable | input | 1 | Bus access phase |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | ADDR_W | Byte address |
| pwdata | input | BUS_W | Write data |
| prdata | output | BUS_W | Read data, valid in access phase |
| pad_in | input | LINES | Pad input values (asynchronous) |
| pad_out | output | LINES | Pad output values |
| pad_oe | output | LINES | Pad output enables |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench builds the block with its defaults: eight lines, a two-stage synchronizer, a 32-bit data bus and a 12-bit address. With eight lines every address mask bit from 2 to 9 has a line behind it, so the single-line offsets and the all-lines offset 0x3FC can both be checked. The two-stage synchronizer fixes the latency. That fixed latency lets the bench place a clear write on exactly the clock edge where an edge event is latched, which is the collision that R11 describes.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

  localparam logic [11:0] OFS_DIR    = 12'h400;
  localparam logic [11:0] OFS_SENSE  = 12'h404;
  localparam logic [11:0] OFS_BOTH   = 12'h408;
  localparam logic [11:0] OFS_POL    = 12'h40C;
  localparam logic [11:0] OFS_IEN    = 12'h410;
  localparam logic [11:0] OFS_RAW    = 12'h414;
  localparam logic [11:0] OFS_MASKED = 12'h418;
  localparam logic [11:0] OFS_CLR    = 12'h41C;

  typedef enum logic [3:0] {
    SEL_DATA,
    SEL_DIR,
    SEL_SENSE,
    SEL_BOTH,
    SEL_POL,
    SEL_IEN,
    SEL_RAW,
    SEL_MASKED,
    SEL_CLR,
    SEL_NONE
  } reg_sel_e;

  function automatic reg_sel_e decode_sel(input logic [11:0] a);
    reg_sel_e s;
    if (a[11:10] == 2'b00) begin
      s = SEL_DATA;
    end else begin
      case ({a[11:2], 2'b00})
        OFS_DIR:    s = SEL_DIR;
        OFS_SENSE:  s = SEL_SENSE;
        OFS_BOTH:   s = SEL_BOTH;
        OFS_POL:    s = SEL_POL;
        OFS_IEN:    s = SEL_IEN;
        OFS_RAW:    s = SEL_RAW;
        OFS_MASKED: s = SEL_MASKED;
        OFS_CLR:    s = SEL_CLR;
        default:    s = SEL_NONE;
      endcase
    end
    return s;
  endfunction

endpackage

// File: rtl/gpio_bank_sync.sv
module gpio_bank_sync #(
  parameter int unsigned W      = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
    end else begin
      stage_q[0] <= din;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_bank_irq.sv
module gpio_bank_irq #(
  parameter int unsigned LINES = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] pin_sync,
  input  logic [LINES-1:0] sense_lvl,
  input  logic [LINES-1:0] both_edge,
  input  logic [LINES-1:0] polarity,
  input  logic [LINES-1:0] irq_en,
  input  logic [LINES-1:0] clr_mask,
  output logic [LINES-1:0] edge_evt,
  output logic [LINES-1:0] edge_stat,
  output logic [LINES-1:0] raw_stat,
  output logic [LINES-1:0] masked_stat,
  output logic             irq
);

  logic [LINES-1:0] pin_prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_prev_q <= '0;
    else        pin_prev_q <= pin_sync;
  end

  for (genvar n = 0; n < LINES; n++) begin : g_line
    logic rise;
    logic fall;
    logic evt;
    logic stat_q;

    assign rise = pin_sync[n] & ~pin_prev_q[n];
    assign fall = ~pin_sync[n] & pin_prev_q[n];

    always_comb begin
      if (sense_lvl[n])      evt = 1'b0;
      else if (both_edge[n]) evt = rise | fall;
      else if (polarity[n])  evt = rise;
      else                   evt = fall;
    end

    // A new event outranks a clear landing on the same edge.
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           stat_q <= 1'b0;
      else if (evt)         stat_q <= 1'b1;
      else if (clr_mask[n]) stat_q <= 1'b0;
    end

    assign edge_evt[n]  = evt;
    assign edge_stat[n] = stat_q;
    assign raw_stat[n]  = sense_lvl[n] ? (pin_sync[n] == polarity[n]) : stat_q;
  end

  assign masked_stat = raw_stat & irq_en;
  assign irq         = |masked_stat;

endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
  import gpio_bank_pkg::*;
#(
  parameter int unsigned LINES = 8,
  parameter int unsigned BUS_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             psel,
  input  logic             penable,
  input  logic             pwrite,
  input  logic [11:0]      addr,
  input  logic [BUS_W-1:0] pwdata,
  output logic [BUS_W-1:0] prdata,
  input  logic [LINES-1:0] pin_sync,
  input  logic [LINES-1:0] raw_stat,
  input  logic [LINES-1:0] masked_stat,
  output logic [LINES-1:0] dir_q,
  output logic [LINES-1:0] sense_q,
  output logic [LINES-1:0] both_q,
  output logic [LINES-1:0] pol_q,
  output logic [LINES-1:0] ien_q,
  output logic [LINES-1:0] out_q,
  output logic [LINES-1:0] clr_mask
);

  localparam int unsigned MASK_LO = 2;
  localparam int unsigned MASK_HI = MASK_LO + LINES - 1;

  reg_sel_e         sel;
  logic             wr_en;
  logic [LINES-1:0] wdat;
  logic [LINES-1:0] line_mask;
  logic [LINES-1:0] wr_lines;
  logic [LINES-1:0] data_view;
  logic [LINES-1:0] rd_val;
  logic             unused_bits;

  assign sel       = decode_sel(addr);
  assign wr_en     = psel & penable & pwrite;
  assign wdat      = pwdata[LINES-1:0];
  assign line_mask = addr[MASK_HI:MASK_LO];
  assign wr_lines  = line_mask & dir_q;
  assign clr_mask  = (wr_en && sel == SEL_CLR) ? wdat : '0;
  assign unused_bits = ^{addr[1:0], pwdata[BUS_W-1:LINES]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q   <= '0;
      sense_q <= '0;
      both_q  <= '0;
      pol_q   <= '0;
      ien_q   <= '0;
      out_q   <= '0;
    end else if (wr_en) begin
      case (sel)
        SEL_DATA:  out_q   <= (out_q & ~wr_lines) | (wdat & wr_lines);
        SEL_DIR:   dir_q   <= wdat;
        SEL_SENSE: sense_q <= wdat;
        SEL_BOTH:  both_q  <= wdat;
        SEL_POL:   pol_q   <= wdat;
        SEL_IEN:   ien_q   <= wdat;
        default:   ;
      endcase
    end
  end

  for (genvar n = 0; n < LINES; n++) begin : g_view
    assign data_view[n] = dir_q[n] ? out_q[n] : pin_sync[n];
  end

  always_comb begin
    case (sel)
      SEL_DATA:   rd_val = data_view & line_mask;
      SEL_DIR:    rd_val = dir_q;
      SEL_SENSE:  rd_val = sense_q;
      SEL_BOTH:   rd_val = both_q;
      SEL_POL:    rd_val = pol_q;
      SEL_IEN:    rd_val = ien_q;
      SEL_RAW:    rd_val = raw_stat;
      SEL_MASKED: rd_val = masked_stat;
      default:    rd_val = '0;
    endcase
  end

  assign prdata = (psel && !pwrite) ? BUS_W'(rd_val) : '0;

endmodule

// File: rtl/gpio_bank.sv
module gpio_bank #(
  parameter int unsigned LINES       = 8,
  parameter int unsigned BUS_W       = 32,
  parameter int unsigned ADDR_W      = 12,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [BUS_W-1:0]  pwdata,
  output logic [BUS_W-1:0]  prdata,
  input  logic [LINES-1:0]  pad_in,
  output logic [LINES-1:0]  pad_out,
  output logic [LINES-1:0]  pad_oe,
  output logic              irq
);

  logic [LINES-1:0] pin_sync;
  logic [LINES-1:0] dir_q, sense_q, both_q, pol_q, ien_q, out_q;
  logic [LINES-1:0] clr_mask;
  logic [LINES-1:0] edge_evt, edge_stat, raw_stat, masked_stat;

  gpio_bank_sync #(.W(LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (pad_in),
    .dout (pin_sync)
  );

  gpio_bank_regs #(.LINES(LINES), .BUS_W(BUS_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .psel       (psel),
    .penable    (penable),
    .pwrite     (pwrite),
    .addr       (paddr[11:0]),
    .pwdata     (pwdata),
    .prdata     (prdata),
    .pin_sync   (pin_sync),
    .raw_stat   (raw_stat),
    .masked_stat(masked_stat),
    .dir_q      (dir_q),
    .sense_q    (sense_q),
    .both_q     (both_q),
    .pol_q      (pol_q),
    .ien_q      (ien_q),
    .out_q      (out_q),
    .clr_mask   (clr_mask)
  );

  gpio_bank_irq #(.LINES(LINES)) u_irq (
    .clk        (clk),
    .rst_n      (rst_n),
    .pin_sync   (pin_sync),
    .sense_lvl  (sense_q),
    .both_edge  (both_q),
    .polarity   (pol_q),
    .irq_en     (ien_q),
    .clr_mask   (clr_mask),
    .edge_evt   (edge_evt),
    .edge_stat  (edge_stat),
    .raw_stat   (raw_stat),
    .masked_stat(masked_stat),
    .irq        (irq)
  );

  assign pad_out = out_q;
  assign pad_oe  = dir_q;

endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk #(
  parameter int unsigned LINES  = 8,
  parameter int unsigned BUS_W  = 32,
  parameter int unsigned ADDR_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              psel,
  input logic              penable,
  input logic              pwrite,
  input logic [ADDR_W-1:0] paddr,
  input logic [BUS_W-1:0]  pwdata,
  input logic [BUS_W-1:0]  prdata,
  input logic [LINES-1:0]  pad_out,
  input logic [LINES-1:0]  pad_oe,
  input logic              irq,
  input logic [LINES-1:0]  edge_evt,
  input logic [LINES-1:0]  edge_stat
);

  logic wr_data, wr_clr, rd_clr, rd_masked;

  assign wr_data   = psel && penable && pwrite && paddr[11:10] == 2'b00;
  assign wr_clr    = psel && penable && pwrite && {paddr[11:2], 2'b00} == 12'h41C;
  assign rd_clr    = psel && penable && !pwrite && {paddr[11:2], 2'b00} == 12'h41C;
  assign rd_masked = psel && penable && !pwrite && {paddr[11:2], 2'b00} == 12'h418;

  p_hold_out_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_data |=> $stable(pad_out));

  p_input_no_effect_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_data |=> ((pad_out ^ $past(pad_out)) & ~$past(pad_oe)) == '0);

  p_no_spurious_r6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (edge_stat & ~$past(edge_stat) & ~$past(edge_evt)) == '0);

  p_irq_matches_masked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_masked |-> (irq == (prdata != '0)));

  p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_clr |=> (edge_stat & $past(pwdata[LINES-1:0] & ~edge_evt)) == '0);

  p_clr_reads_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_clr |-> prdata == '0);

  p_event_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_evt != '0) |=> (edge_stat & $past(edge_evt)) == $past(edge_evt));

endmodule

bind gpio_bank gpio_bank_chk #(.LINES(LINES), .BUS_W(BUS_W), .ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .psel     (psel),
  .penable  (penable),
  .pwrite   (pwrite),
  .paddr    (paddr),
  .pwdata   (pwdata),
  .prdata   (prdata),
  .pad_out  (pad_out),
  .pad_oe   (pad_oe),
  .irq      (irq),
  .edge_evt (edge_evt),
  .edge_stat(edge_stat)
);

// File: tb/gpio_bank_bench.sv
`timescale 1ns/1ps
module gpio_bank_bench;

  localparam logic [11:0] A_DIR = 12'h400, A_SENSE = 12'h404, A_BOTH = 12'h408,
                          A_POL = 12'h40C, A_IEN = 12'h410, A_RAW = 12'h414,
                          A_MASK = 12'h418, A_CLR = 12'h41C;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic [7:0]  pad_in = '0;
  logic [7:0]  pad_out, pad_oe;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  gpio_bank u_gpio_bank (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); psel = 1; penable = 0; pwrite = 1; paddr = a; pwdata = d;
    @(negedge clk); penable = 1;
    @(negedge clk); psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic bus_rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); psel = 1; penable = 0; pwrite = 0; paddr = a;
    @(negedge clk); penable = 1;
    #1 d = prdata;
    @(negedge clk); psel = 0; penable = 0;
  endtask

  task automatic set_pad(input logic [7:0] v);
    @(negedge clk); pad_in = v;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    #1;
    check("R1 pad_oe", pad_oe, 0);
    check("R1 pad_out", pad_out, 0);
    check("R1 irq", irq, 0);
    bus_rd(A_DIR, d); check("R1 dir reg", d, 0);
    bus_rd(A_IEN, d); check("R1 enable reg", d, 0);
  endtask

  task automatic t_data;
    logic [31:0] d;
    bus_wr(A_DIR, 32'h0F);
    #1 check("R2 pad_oe", pad_oe, 8'h0F);
    bus_rd(A_DIR, d); check("R2 dir readback", d, 32'h0F);
    bus_wr(12'h3FC, 32'hFF);
    #1 check("R3 all-mask write, inputs untouched", pad_out, 8'h0F);
    bus_wr(12'h008, 32'h00);
    #1 check("R3 single line 1 write", pad_out, 8'h0D);
    bus_wr(12'h030, 32'h00);
    #1 check("R3 lines 2,3 write", pad_out, 8'h01);
    set_pad(8'hA0);
    bus_rd(12'h3FC, d); check("R4 full mask read", d, 32'hA1);
    bus_rd(12'h200, d); check("R4 line 7 read", d, 32'h80);
    bus_rd(12'h004, d); check("R4 line 0 output read", d, 32'h01);
    bus_rd(12'h010, d); check("R4 line 2 read", d, 32'h00);
    bus_rd(12'h0FC, d); check("R4 unmasked line 7 reads zero", d, 32'h21);
  endtask

  task automatic t_level;
    logic [31:0] d;
    bus_wr(A_SENSE, 32'h10);
    bus_wr(A_POL, 32'h10);
    bus_wr(A_IEN, 32'h10);
    #1 check("R8 idle level irq", irq, 0);
    @(negedge clk); pad_in[4] = 1'b1;
    @(posedge clk); #1 check("R5 one edge after pad change", irq, 0);
    @(posedge clk); #1 check("R5 two edges after pad change", irq, 1);
    bus_rd(A_MASK, d); check("R9 masked level", d, 32'h10);
    set_pad(8'hA0);
    #1 check("R8 level drops with input", irq, 0);
    bus_wr(A_POL, 32'h00);
    bus_rd(A_RAW, d); check("R8 active low raw", d & 32'h10, 32'h10);
    bus_wr(A_CLR, 32'h10);
    bus_rd(A_RAW, d); check("R8 clear leaves level", d & 32'h10, 32'h10);
    bus_wr(A_IEN, 0); bus_wr(A_SENSE, 0); bus_wr(A_CLR, 32'hFF);
  endtask

  task automatic t_edge;
    logic [31:0] d;
    bus_wr(A_POL, 32'h20);
    set_pad(8'h80);
    bus_rd(A_RAW, d); check("R6 falling ignored for rising", d & 32'h20, 0);
    set_pad(8'hA0);
    bus_rd(A_RAW, d); check("R6 rising latched", d & 32'h20, 32'h20);
    set_pad(8'h80);
    bus_rd(A_RAW, d); check("R6 stays latched", d & 32'h20, 32'h20);
    bus_rd(A_MASK, d); check("R9 masked off", d, 0);
    #1 check("R9 irq off", irq, 0);
    bus_wr(A_IEN, 32'h20);
    #1 check("R9 irq on", irq, 1);
    bus_rd(A_MASK, d); check("R9 masked on", d, 32'h20);
    bus_wr(A_CLR, 32'h20);
    bus_rd(A_RAW, d); check("R10 cleared", d & 32'h20, 0);
    #1 check("R10 irq after clear", irq, 0);
    bus_rd(A_CLR, d); check("R10 clear reads zero", d, 0);
    set_pad(8'hC0);
    bus_rd(A_RAW, d); check("R6 rising ignored for falling", d & 32'h40, 0);
    set_pad(8'h80);
    bus_rd(A_RAW, d); check("R6 falling latched", d & 32'h40, 32'h40);
    bus_wr(A_CLR, 32'hFF); bus_wr(A_IEN, 0);
  endtask

  task automatic t_both;
    logic [31:0] d;
    bus_wr(A_BOTH, 32'h80);
    bus_wr(A_POL, 32'h00);
    set_pad(8'h00);
    bus_rd(A_RAW, d); check("R7 falling edge", d & 32'h80, 32'h80);
    bus_wr(A_CLR, 32'h80);
    bus_rd(A_RAW, d); check("R7 cleared", d & 32'h80, 0);
    set_pad(8'h80);
    bus_rd(A_RAW, d); check("R7 rising despite polarity 0", d & 32'h80, 32'h80);
    bus_wr(A_CLR, 32'h80); bus_wr(A_BOTH, 0);
  endtask

  task automatic t_race;
    logic [31:0] d;
    bus_wr(A_POL, 32'h40);
    bus_wr(A_CLR, 32'hFF);
    @(negedge clk); pad_in = 8'hC0;
    @(negedge clk); psel = 1; penable = 0; pwrite = 1; paddr = A_CLR; pwdata = 32'h40;
    @(negedge clk); penable = 1;
    @(negedge clk); psel = 0; penable = 0; pwrite = 0;
    bus_rd(A_RAW, d); check("R11 event beats clear", d & 32'h40, 32'h40);
    bus_wr(A_CLR, 32'h40);
    bus_rd(A_RAW, d); check("R11 later clear works", d & 32'h40, 0);
  endtask

  task automatic t_readonly;
    logic [31:0] d;
    set_pad(8'h80);
    set_pad(8'hC0);
    bus_wr(A_RAW, 32'h00);
    bus_rd(A_RAW, d); check("R12 raw write ignored", d & 32'h40, 32'h40);
    bus_wr(A_IEN, 32'h40);
    bus_wr(A_MASK, 32'h00);
    bus_rd(A_MASK, d); check("R12 masked write ignored", d, 32'h40);
    bus_wr(A_CLR, 32'hFF);
    bus_wr(A_RAW, 32'hFF);
    bus_rd(A_RAW, d); check("R12 raw write cannot set", d, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    t_reset();
    t_data();
    t_level();
    t_edge();
    t_both();
    t_race();
    t_readonly();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule